// File: doc/BRIEF.md
# DMA Acknowledge Terminal-Count Generator

This block sits between a disk controller and a DMA engine that has no terminal-count output of its own. It counts acknowledge cycles from the DMA engine against a maximum that software loads before a transfer starts. When the final acknowledge arrives it waits a fixed delay and then drives a terminal-count pulse back to the controller, so the controller stops requesting bytes. The pulse reaches the controller only while a separate enable bit is set.

The block also conditions the controller's byte request on its way to the DMA engine: a request is passed on only after it has been held for a fixed delay, and it is withdrawn a short, fixed time after the acknowledge is seen. All delays are clock-cycle counts derived from a clock-frequency parameter (MHz) and nanosecond parameters: a delay of `N` ns becomes `CLK_MHZ*N/1000` cycles, never less than one.

Two state machines do the work. The request shaper has states `SH_IDLE`, `SH_WAIT`, `SH_ASSERT`, `SH_DROP` and `SH_HOLD`, with transitions idle→wait (request seen), wait→idle (request withdrawn early), wait→assert (delay expired), assert→drop (acknowledge seen), drop→hold (drop delay expired) and hold→idle (acknowledge released). The counter has states `CT_IDLE`, `CT_COUNT`, `CT_DELAY` and `CT_PULSE`, with transitions idle/any→count (non-zero maximum written), any→idle (zero written), count→delay (count reaches maximum), delay→pulse (terminal-count delay expired) and pulse→idle (pulse length reached).

Top module: `ack_tc_gen`

## Requirements
- R1: After reset `eng_drq` and `ctl_tc` are 0, the counter is disarmed and the enable bit is 0.
- R2: With `ctl_dreq` held high, `eng_drq` rises exactly REQ_DLY clock edges after the first edge that samples `ctl_dreq` high (REQ_DLY = CLK_MHZ*REQ_NS/1000, 250 by default).
- R3: If `ctl_dreq` falls before the request delay expires, `eng_drq` never rises for that request.
- R4: Once `eng_drq` is high, the first edge sampling `eng_dack` high starts a DROP_DLY-cycle timer (default 50); `eng_drq` falls when it expires and stays low until an edge samples `eng_dack` low, after which a held `ctl_dreq` starts a fresh request delay.
- R5: The count rises by one per low-to-high transition of `eng_dack`, however many cycles the acknowledge is held.
- R6: A cycle with `max_wr`=1 loads `max_wdata` as the maximum and clears the count to zero; a non-zero value arms counting, zero leaves the counter disarmed so no acknowledge produces a terminal count.
- R7: When the count reaches the maximum, the terminal-count pulse goes high TC_DLY edges after the edge that sampled the final acknowledge (TC_DLY = CLK_MHZ*TC_NS/1000, 4500 by default) and stays high for TC_PULSE clock cycles (8 by default).
- R8: After the pulse, and while the terminal-count delay runs, the counter ignores acknowledges and holds; only a new maximum write rearms it.
- R9: `en_wr`=1 loads `en_wdata` into the enable bit; `ctl_tc` shows the pulse only while that bit is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| max_wr | input | 1 | Write strobe for the maximum count |
| max_wdata | input | CNT_W | Maximum acknowledge count |
| en_wr | input | 1 | Write strobe for the enable bit |
| en_wdata | input | 1 | Enable bit value for the terminal-count output |
| ctl_dreq | input | 1 | Raw byte request from the disk controller |
| eng_drq | output | 1 | Delayed, conditioned request to the DMA engine |
| eng_dack | input | 1 | Acknowledge from the DMA engine |
| ctl_tc | output | 1 | Terminal-count pulse to the disk controller |

## Verification
The bench measures request delay, drop delay, terminal-count latency and pulse width in exact cycles, so an off-by-one counter or a missing register shows as a wrong cycle count. It holds an acknowledge for many cycles to catch a design that counts levels instead of edges, and rewrites the maximum in mid-transfer to catch one that forgets to clear the count. It checks that a zero maximum, a cleared enable bit and acknowledges arriving after the pulse all leave `ctl_tc` low; a design that kept counting after the pulse or ignored the enable would raise a second pulse. A request withdrawn early must never reach the DMA engine, which a shaper that latched the request would violate.

// File: rtl/tcg_pkg.sv
package tcg_pkg;

    typedef enum logic [2:0] {
        SH_IDLE,
        SH_WAIT,
        SH_ASSERT,
        SH_DROP,
        SH_HOLD
    } shaper_state_t;

    typedef enum logic [1:0] {
        CT_IDLE,
        CT_COUNT,
        CT_DELAY,
        CT_PULSE
    } counter_state_t;

    function automatic int ns_to_cycles(input int clk_mhz, input int ns);
        int c;
        c = (clk_mhz * ns) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/tcg_req_shaper.sv
module tcg_req_shaper
    import tcg_pkg::*;
#(
    parameter int REQ_DLY  = 250,
    parameter int DROP_DLY = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dreq,
    input  logic dack,
    output logic drq
);

    localparam int TW = $clog2(max_of(REQ_DLY, DROP_DLY) + 1);
    localparam logic [TW-1:0] REQ_LAST  = TW'(REQ_DLY - 1);
    localparam logic [TW-1:0] DROP_LAST = TW'(DROP_DLY - 1);

    shaper_state_t st_q, st_nx;
    logic [TW-1:0] tmr_q;

    // next-state selection
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            SH_IDLE:   if (dreq) st_nx = SH_WAIT;
            SH_WAIT: begin
                if (!dreq)                  st_nx = SH_IDLE;
                else if (tmr_q == REQ_LAST) st_nx = SH_ASSERT;
            end
            SH_ASSERT: if (dack) st_nx = SH_DROP;
            SH_DROP:   if (tmr_q == DROP_LAST) st_nx = SH_HOLD;
            SH_HOLD:   if (!dack) st_nx = SH_IDLE;
            default:   st_nx = SH_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= SH_IDLE;
        else        st_q <= st_nx;
    end

    // delay timer, restarted on every state change
    always_ff @(posedge clk) begin
        if (!rst_n)              tmr_q <= '0;
        else if (st_nx != st_q)  tmr_q <= '0;
        else if (st_q == SH_WAIT || st_q == SH_DROP) tmr_q <= tmr_q + TW'(1);
    end

    // outputs
    always_comb begin
        drq = (st_q == SH_ASSERT) || (st_q == SH_DROP);
    end

    // R2
    drq_rise_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drq) |-> $past(dreq));

    // R3
    no_req_no_drq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dreq && !drq) |=> !drq);

    // R4
    hold_keeps_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SH_HOLD && dack) |=> !drq);

endmodule

// File: rtl/tcg_ack_counter.sv
module tcg_ack_counter
    import tcg_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int TC_DLY   = 4500,
    parameter int TC_PULSE = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             max_wr,
    input  logic [CNT_W-1:0] max_wdata,
    input  logic             dack,
    output logic             tc_raw
);

    localparam int TW = $clog2(max_of(TC_DLY, TC_PULSE) + 1);
    localparam logic [TW-1:0] DLY_LAST = TW'(TC_DLY - 1);
    localparam logic [TW-1:0] PLS_LAST = TW'(TC_PULSE - 1);

    counter_state_t st_q, st_nx;
    logic [CNT_W-1:0] max_q, cnt_q;
    logic [TW-1:0]    tmr_q;
    logic             dack_q;
    logic             dack_rise;
    logic             hit;

    always_comb begin
        dack_rise = dack && !dack_q;
        hit       = dack_rise && ((cnt_q + CNT_W'(1)) == max_q);
    end

    // next-state selection
    always_comb begin
        st_nx = st_q;
        if (max_wr) begin
            st_nx = (max_wdata != '0) ? CT_COUNT : CT_IDLE;
        end else begin
            unique case (st_q)
                CT_IDLE:  st_nx = CT_IDLE;
                CT_COUNT: if (hit) st_nx = CT_DELAY;
                CT_DELAY: if (tmr_q == DLY_LAST) st_nx = CT_PULSE;
                CT_PULSE: if (tmr_q == PLS_LAST) st_nx = CT_IDLE;
                default:  st_nx = CT_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CT_IDLE;
        else        st_q <= st_nx;
    end

    // datapath: edge detector, count, maximum, timer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dack_q <= 1'b0;
            max_q  <= '0;
            cnt_q  <= '0;
            tmr_q  <= '0;
        end else begin
            dack_q <= dack;
            if (max_wr) begin
                max_q <= max_wdata;
                cnt_q <= '0;
                tmr_q <= '0;
            end else begin
                unique case (st_q)
                    CT_IDLE: begin
                        cnt_q <= '0;
                        tmr_q <= '0;
                    end
                    CT_COUNT: begin
                        if (dack_rise) cnt_q <= cnt_q + CNT_W'(1);
                        tmr_q <= '0;
                    end
                    CT_DELAY: begin
                        tmr_q <= (tmr_q == DLY_LAST) ? '0 : tmr_q + TW'(1);
                    end
                    CT_PULSE: begin
                        if (tmr_q == PLS_LAST) begin
                            tmr_q <= '0;
                            cnt_q <= '0;
                        end else begin
                            tmr_q <= tmr_q + TW'(1);
                        end
                    end
                    default: tmr_q <= '0;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        tc_raw = (st_q == CT_PULSE);
    end

    // R5
    count_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CT_COUNT && !dack_rise && !max_wr) |=> $stable(cnt_q));

    // R5
    count_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != CT_IDLE) |-> (cnt_q <= max_q));

    // R8
    disarmed_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CT_IDLE && !max_wr) |=> (st_q == CT_IDLE && cnt_q == '0));

    // R7
    pulse_after_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tc_raw) |-> ($past(st_q) == CT_DELAY && cnt_q == max_q));

endmodule

// File: rtl/ack_tc_gen.sv
module ack_tc_gen
    import tcg_pkg::*;
#(
    parameter int CLK_MHZ       = 250,
    parameter int CNT_W         = 16,
    parameter int REQ_NS        = 1000,
    parameter int DROP_NS       = 200,
    parameter int TC_NS         = 18000,
    parameter int TC_PULSE_CLKS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             max_wr,
    input  logic [CNT_W-1:0] max_wdata,
    input  logic             en_wr,
    input  logic             en_wdata,
    input  logic             ctl_dreq,
    output logic             eng_drq,
    input  logic             eng_dack,
    output logic             ctl_tc
);

    localparam int REQ_DLY  = ns_to_cycles(CLK_MHZ, REQ_NS);
    localparam int DROP_DLY = ns_to_cycles(CLK_MHZ, DROP_NS);
    localparam int TC_DLY   = ns_to_cycles(CLK_MHZ, TC_NS);
    localparam int TC_PULSE = (TC_PULSE_CLKS < 1) ? 1 : TC_PULSE_CLKS;

    logic en_q;
    logic tc_raw;

    tcg_req_shaper #(
        .REQ_DLY (REQ_DLY),
        .DROP_DLY(DROP_DLY)
    ) u_shaper (
        .clk  (clk),
        .rst_n(rst_n),
        .dreq (ctl_dreq),
        .dack (eng_dack),
        .drq  (eng_drq)
    );

    tcg_ack_counter #(
        .CNT_W   (CNT_W),
        .TC_DLY  (TC_DLY),
        .TC_PULSE(TC_PULSE)
    ) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .max_wr   (max_wr),
        .max_wdata(max_wdata),
        .dack     (eng_dack),
        .tc_raw   (tc_raw)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= 1'b0;
        else if (en_wr) en_q <= en_wdata;
    end

    always_comb begin
        ctl_tc = tc_raw && en_q;
    end

    // R9
    tc_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> !ctl_tc);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (!eng_drq && !ctl_tc));

endmodule

// File: tb/ack_tc_gen_bench.sv
module ack_tc_gen_bench;

    localparam int CNT_W  = 16;
    localparam int MHZ    = 250;
    localparam int REQ_C  = MHZ * 1000 / 1000;
    localparam int DROP_C = MHZ * 200 / 1000;
    localparam int TC_C   = MHZ * 18000 / 1000;
    localparam int PLS_C  = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             max_wr = 1'b0;
    logic [CNT_W-1:0] max_wdata = '0;
    logic             en_wr = 1'b0;
    logic             en_wdata = 1'b0;
    logic             ctl_dreq = 1'b0;
    logic             eng_drq;
    logic             eng_dack = 1'b0;
    logic             ctl_tc;

    int vectors = 0;
    int miscompares = 0;
    int tc_seen = 0;
    int drq_seen = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ack_tc_gen #(.CLK_MHZ(MHZ), .CNT_W(CNT_W)) u_ack_tc_gen (
        .clk(clk), .rst_n(rst_n), .max_wr(max_wr), .max_wdata(max_wdata),
        .en_wr(en_wr), .en_wdata(en_wdata), .ctl_dreq(ctl_dreq),
        .eng_drq(eng_drq), .eng_dack(eng_dack), .ctl_tc(ctl_tc)
    );

    always begin
        @(posedge clk);
        #1;
        if (ctl_tc)  tc_seen++;
        if (eng_drq) drq_seen++;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit sig(input int which);
        return (which == 0) ? eng_drq : ctl_tc;
    endfunction

    task automatic cycles_until(input int which, input bit lvl, input int cap, output int k);
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (k < cap && sig(which) != lvl);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_max(input int v);
        @(negedge clk);
        max_wr = 1'b1;
        max_wdata = CNT_W'(v);
        @(negedge clk);
        max_wr = 1'b0;
    endtask

    task automatic set_en(input bit b);
        @(negedge clk);
        en_wr = 1'b1;
        en_wdata = b;
        @(negedge clk);
        en_wr = 1'b0;
    endtask

    task automatic ack_pulse(input int len);
        @(negedge clk);
        eng_dack = 1'b1;
        idle(len);
        eng_dack = 1'b0;
        idle(2);
    endtask

    task automatic t_reset;
        check(eng_drq == 1'b0, "R1 drq after reset", eng_drq, 0);
        check(ctl_tc == 1'b0, "R1 tc after reset", ctl_tc, 0);
    endtask

    task automatic t_req_path;
        int k;
        @(negedge clk);
        ctl_dreq = 1'b1;
        cycles_until(0, 1'b1, 2000, k);
        check(k == REQ_C + 1, "R2 request delay", k, REQ_C + 1);
        @(negedge clk);
        eng_dack = 1'b1;
        cycles_until(0, 1'b0, 2000, k);
        check(k == DROP_C + 1, "R4 drop delay", k, DROP_C + 1);
        idle(20);
        check(eng_drq == 1'b0, "R4 low while ack held", eng_drq, 0);
        eng_dack = 1'b0;
        cycles_until(0, 1'b1, 2000, k);
        check(k == REQ_C + 2, "R4 fresh delay after release", k, REQ_C + 2);
        @(negedge clk);
        eng_dack = 1'b1;
        idle(4);
        eng_dack = 1'b0;
        ctl_dreq = 1'b0;
        idle(DROP_C + 10);
        check(eng_drq == 1'b0, "R4 drq low after cycle", eng_drq, 0);
    endtask

    task automatic t_req_cancel;
        int base;
        base = drq_seen;
        @(negedge clk);
        ctl_dreq = 1'b1;
        idle(100);
        ctl_dreq = 1'b0;
        idle(2 * REQ_C);
        check(drq_seen == base, "R3 withdrawn request", drq_seen - base, 0);
    endtask

    task automatic t_tc_basic;
        int k;
        int w;
        int base;
        set_en(1'b1);
        write_max(3);
        ack_pulse(4);
        ack_pulse(4);
        base = tc_seen;
        idle(TC_C + 100);
        check(tc_seen == base, "R7 no pulse before maximum", tc_seen - base, 0);
        @(negedge clk);
        eng_dack = 1'b1;
        cycles_until(1, 1'b1, TC_C + 500, k);
        check(k == TC_C + 1, "R7 terminal-count latency", k, TC_C + 1);
        w = 0;
        while (ctl_tc && w < 100) begin
            w++;
            @(negedge clk);
        end
        check(w == PLS_C, "R7 pulse width", w, PLS_C);
        eng_dack = 1'b0;
        idle(2);
    endtask

    task automatic t_after_pulse;
        int base;
        base = tc_seen;
        ack_pulse(3);
        ack_pulse(3);
        ack_pulse(3);
        idle(TC_C + 100);
        check(tc_seen == base, "R8 held after pulse", tc_seen - base, 0);
    endtask

    task automatic t_rewrite;
        int base;
        base = tc_seen;
        write_max(3);
        ack_pulse(3);
        ack_pulse(3);
        write_max(3);
        ack_pulse(3);
        ack_pulse(3);
        idle(TC_C + 100);
        check(tc_seen == base, "R6 rewrite clears count", tc_seen - base, 0);
        ack_pulse(3);
        idle(TC_C + PLS_C + 50);
        check(tc_seen - base == PLS_C, "R6 count after rewrite", tc_seen - base, PLS_C);
    endtask

    task automatic t_zero_max;
        int base;
        base = tc_seen;
        write_max(0);
        ack_pulse(3);
        ack_pulse(3);
        idle(TC_C + 100);
        check(tc_seen == base, "R6 zero maximum disarmed", tc_seen - base, 0);
    endtask

    task automatic t_held_ack;
        int base;
        base = tc_seen;
        write_max(2);
        ack_pulse(30);
        idle(TC_C + 100);
        check(tc_seen == base, "R5 held ack counts once", tc_seen - base, 0);
        ack_pulse(3);
        idle(TC_C + PLS_C + 50);
        check(tc_seen - base == PLS_C, "R5 second ack reaches max", tc_seen - base, PLS_C);
    endtask

    task automatic t_enable;
        int base;
        base = tc_seen;
        set_en(1'b0);
        write_max(1);
        ack_pulse(3);
        idle(TC_C + PLS_C + 50);
        check(tc_seen == base, "R9 disabled output", tc_seen - base, 0);
        set_en(1'b1);
        write_max(1);
        ack_pulse(3);
        idle(TC_C + PLS_C + 50);
        check(tc_seen - base == PLS_C, "R9 enabled output", tc_seen - base, PLS_C);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        idle(5);
        rst_n = 1'b1;
        idle(2);
        t_reset;
        t_req_path;
        t_req_cancel;
        t_tc_basic;
        t_after_pulse;
        t_rewrite;
        t_zero_max;
        t_held_ack;
        t_enable;
        finish_run;
    end

    initial begin
        #(4 * 150000);
        vectors++;
        miscompares++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run;
    end

endmodule